// File: doc/BRIEF.md
# DMA Request Router with Periodic Gating

This block sits between a large set of peripheral DMA request lines and a smaller set of DMA channel request inputs on the DMA engine. Each channel has its own 8-bit configuration register. The register turns the channel on or off, chooses one peripheral slot as the channel's request source, and on the lowest-numbered channels can also turn on gating by an external periodic timer.

In gated mode a channel raises its request only on cycles where the timer pulse for that channel and the selected source request are both high. A peripheral can therefore be serviced at a fixed rate without software involvement. Software normally writes the configuration once at start-up. It should clear the enable before it changes a channel's source.

Every channel output is registered, so the request the engine sees lags the inputs by one clock.

Top module: `dma_req_router`

## Requirements
- R1: After reset every configuration register reads 0x00 and every channel request output is 0, whatever the inputs do.
- R2: Configuration bit 7 is the channel enable. While it is 0 the channel's request output is 0 on every cycle.
- R3: With bit 7 set and bit 6 clear (plain routing), the channel output on a cycle equals the selected source request of the previous cycle.
- R4: With bits 7 and 6 both set on a gated channel (index below NUM_TRIG = 4), the output equals the previous cycle's selected source request ANDed with that channel's timer pulse from the same previous cycle.
- R5: Configuration bits 5:0 hold the source slot number, and slot n selects request input n. Slot 0 selects nothing, so the output stays 0 even when the channel is enabled.
- R6: On channels NUM_TRIG and above, bit 6 has no effect on the output. It always reads back as 0.
- R7: A write to a channel's register takes effect from the next clock edge, and bits 7 and 5:0 read back exactly as written.
- R8: Channels are independent, and two channels may select the same source at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Channel index for write and read |
| cfg_wdata | input | 8 | Write data: bit 7 enable, bit 6 gate enable, bits 5:0 slot |
| cfg_rdata | output | 8 | Read data of the channel selected by cfg_addr (combinational) |
| src_req | input | 64 | Peripheral request lines, indexed by slot |
| trig_pulse | input | 4 | Periodic timer pulses, one per gated channel |
| ch_req | output | 8 | Registered request to each DMA channel |

## Verification
The bench sweeps every channel through all 64 slot values under all four enable and gate combinations. Against each setting it applies a one-hot source, its complement and an all-ones source. These patterns expose a slot decode that is off by one: with a one-hot source such a design drives no request where one is expected, and with the complement it drives one where none is expected. Slot 0 is swept with an all-ones source, so a design that treated slot 0 as a real source would raise a request there. Timer pulses are varied on the upper channels, so a design that honoured bit 6 above channel 3 would drop requests, and its readback would return a 1 in bit 6. Checking every output bit on every step also catches a write that lands on the wrong channel or a channel that leaks into its neighbour.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
    localparam int SLOT_W  = 6;
    localparam int CFG_W   = 8;
    localparam int SLOT_SP = 1 << SLOT_W;

    typedef struct packed {
        logic              en;
        logic              gate;
        logic [SLOT_W-1:0] slot;
    } ch_cfg_t;
endpackage

// File: rtl/dmr_cfg_regs.sv
module dmr_cfg_regs
    import dmr_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int NUM_TRIG = 4,
    localparam int AW      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          addr,
    input  logic [CFG_W-1:0]       wdata,
    output logic [CFG_W-1:0]       rdata,
    output ch_cfg_t [NUM_CH-1:0]   cfg_o
);
    typedef struct packed {
        ch_cfg_t [NUM_CH-1:0] cfg;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        rdata  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (we && addr == AW'(i)) begin
                regs_d.cfg[i] = ch_cfg_t'(wdata);
                if (i >= NUM_TRIG) regs_d.cfg[i].gate = 1'b0;
            end
            if (addr == AW'(i)) rdata = regs_q.cfg[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign cfg_o = regs_q.cfg;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (we && addr == AW'(g)) |=> (cfg_o[g].slot == $past(wdata[SLOT_W-1:0])
                                        && cfg_o[g].en == $past(wdata[7])));
        if (g >= NUM_TRIG) begin : g_hi
            a_r6_gate_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (we && addr == AW'(g)) |=> !cfg_o[g].gate);
        end
    end
endmodule

// File: rtl/dmr_channel.sv
module dmr_channel
    import dmr_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter bit TRIG_CAP = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ch_cfg_t            cfg,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               trig,
    output logic               req
);
    typedef struct packed {
        logic req;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic [SLOT_SP-1:0] src_pad;
    logic               sel;
    logic               gated;

    assign src_pad = SLOT_SP'(src_req);

    always_comb begin
        sel        = (cfg.slot != '0) && src_pad[cfg.slot];
        gated      = TRIG_CAP && cfg.gate;
        st_d       = st_q;
        st_d.req   = cfg.en && sel && (!gated || trig);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req = st_q.req;

    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> !req);
    a_r5_slot0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.slot == '0) |=> !req);
    a_r3_plain_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && !(TRIG_CAP && cfg.gate) && cfg.slot != '0)
            |=> (req == $past(src_pad[cfg.slot])));
    if (TRIG_CAP) begin : g_gate_chk
        a_r4_no_pulse_no_req: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg.en && cfg.gate && !trig) |=> !req);
    end
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
    import dmr_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int NUM_SRC  = 64,
    parameter int NUM_TRIG = 4,
    localparam int AW      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [CFG_W-1:0]    cfg_rdata,
    input  logic [NUM_SRC-1:0]  src_req,
    input  logic [NUM_TRIG-1:0] trig_pulse,
    output logic [NUM_CH-1:0]   ch_req
);
    ch_cfg_t [NUM_CH-1:0] cfg;

    dmr_cfg_regs #(.NUM_CH(NUM_CH), .NUM_TRIG(NUM_TRIG)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg_o (cfg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        if (c < NUM_TRIG) begin : g_gated
            dmr_channel #(.NUM_SRC(NUM_SRC), .TRIG_CAP(1'b1)) u_ch (
                .clk(clk), .rst_n(rst_n), .cfg(cfg[c]), .src_req(src_req),
                .trig(trig_pulse[c]), .req(ch_req[c])
            );
        end else begin : g_plain
            dmr_channel #(.NUM_SRC(NUM_SRC), .TRIG_CAP(1'b0)) u_ch (
                .clk(clk), .rst_n(rst_n), .cfg(cfg[c]), .src_req(src_req),
                .trig(1'b0), .req(ch_req[c])
            );
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (ch_req == '0));
endmodule

// File: tb/sim_dma_req_router.sv
module sim_dma_req_router;
    localparam int NCH = 8;
    localparam int NSRC = 64;
    localparam int NTRG = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [2:0]      cfg_addr = '0;
    logic [7:0]      cfg_wdata = '0;
    logic [7:0]      cfg_rdata;
    logic [NSRC-1:0] src_req = '0;
    logic [NTRG-1:0] trig_pulse = '0;
    logic [NCH-1:0]  ch_req;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;
    logic [7:0] model [NCH];

    always #4 clk = ~clk;

    dma_req_router u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_req(src_req),
        .trig_pulse(trig_pulse), .ch_req(ch_req)
    );

    function automatic logic exp_bit(int c, logic [NSRC-1:0] s, logic [NTRG-1:0] t);
        logic en, gt;
        logic [5:0] sl;
        en = model[c][7];
        gt = (c < NTRG) && model[c][6];
        sl = model[c][5:0];
        return en && (sl != 0) && s[sl] && (!gt || (c < NTRG && t[c % NTRG]));
    endfunction

    function automatic string tag_of(int c);
        if (!model[c][7])        return "R2";
        if (model[c][5:0] == 0)  return "R5";
        if (c < NTRG && model[c][6]) return "R4";
        if (model[c][6])         return "R6";
        return "R3";
    endfunction

    task automatic wr(int c, logic [7:0] d);
        logic [7:0] e;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(c); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        e = d;
        if (c >= NTRG) e[6] = 1'b0;
        model[c] = e;
        checks++;
        if (cfg_rdata !== e) begin
            errors++;
            $display("FAIL %s readback ch%0d: got %h expected %h",
                     (c >= NTRG && d[6]) ? "R6" : "R7", c, cfg_rdata, e);
        end
    endtask

    task automatic stim(logic [NSRC-1:0] s, logic [NTRG-1:0] t, string extra);
        logic [NCH-1:0] e;
        @(negedge clk);
        src_req = s; trig_pulse = t;
        for (int c = 0; c < NCH; c++) e[c] = exp_bit(c, s, t);
        @(negedge clk);
        checks++;
        if (ch_req !== e) begin
            errors++;
            for (int c = 0; c < NCH; c++)
                if (ch_req[c] !== e[c])
                    $display("FAIL %s%s ch%0d cfg=%h: got %b expected %b (vec got %b exp %b)",
                             tag_of(c), extra, c, model[c], ch_req[c], e[c], ch_req, e);
        end
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) model[c] = 8'h00;
        src_req = '1; trig_pulse = '1;
        repeat (3) @(negedge clk);
        // R1: outputs stay idle in reset
        checks++;
        if (ch_req !== '0) begin errors++; $display("FAIL R1 in reset: got %b expected 0", ch_req); end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: registers read 0x00 and outputs 0 after reset
        for (int c = 0; c < NCH; c++) begin
            cfg_addr = 3'(c);
            #1;
            checks++;
            if (cfg_rdata !== 8'h00) begin
                errors++; $display("FAIL R1 reset read ch%0d: got %h expected 00", c, cfg_rdata);
            end
        end
        checks++;
        if (ch_req !== '0) begin errors++; $display("FAIL R1 after reset: got %b expected 0", ch_req); end

        // R2 R3 R4 R5 R6 R7: sweep channels, slots and mode bits
        for (int c = 0; c < NCH; c++) begin
            for (int sl = 0; sl < NSRC; sl++) begin
                for (int m = 0; m < 4; m++) begin
                    logic [NSRC-1:0] oh;
                    oh = NSRC'(1) << sl;
                    wr(c, {m[1], m[0], 6'(sl)});
                    stim(oh, 4'hF, " onehot");
                    stim(~oh, 4'(sl), " complement");
                    stim('1, 4'hA ^ 4'(m), " allones");
                end
            end
            wr(c, 8'h00);
        end

        // R8: two channels share one source
        wr(1, 8'hC9);
        wr(6, 8'h89);
        stim(NSRC'(1) << 9, 4'h0, " shared");
        stim(NSRC'(1) << 9, 4'h2, " shared");
        stim(NSRC'(1) << 10, 4'hF, " shared");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule